// File: doc/BRIEF.md
# Polled Half-Duplex Synchronous Serial Master

This block is a serial master that moves one byte at a time to or from one of two external slave devices over a single shared data line. The line is bidirectional. Each transfer only sends or only receives. The pad is modelled as three separate signals: an output value `sdo`, an output enable `sdo_oe` and an input value `sdi`. Software runs the block through a small register port. It picks a slave and a clock rate in a control register. Writing the transmit register starts a send, and writing a command bit starts a receive. Software then polls a status register until the busy flag clears. There is no interrupt.

The serial clock idles low and runs at the system clock divided by 2, 4, 8 or 16, so a 50 MHz system gives up to 25 Mbit/s. Bits travel most-significant first. The master changes outgoing data on the falling edge of the serial clock and samples incoming data on the rising edge. The slave enable is driven from the control register, not by the transfer engine. It stays asserted across back-to-back transfers until software clears it, which allows multi-byte transactions.

The sequencer has three states. `ST_IDLE` has the clock low and no transfer running. `ST_LOW` is the low half of a bit. `ST_HIGH` is the high half of a bit. The transitions are:
- `ST_IDLE` → `ST_LOW` on a start.
- `ST_LOW` → `ST_HIGH` when a half period expires (the rising edge).
- `ST_HIGH` → `ST_LOW` when a half period expires before the last bit (the falling edge).
- `ST_HIGH` → `ST_IDLE` when a half period expires after the last bit (finish).

Top module: `sync_serial_master`

## Requirements
- R1: After reset:
  - `sclk` is 0 and `sel_n` is 2'b11.
  - `sdo_oe` is 0.
  - The control register, the receive register, busy and done are all 0.
- R2: A write to address 1 while idle starts a send transfer. Busy (status bit 0) is 1 from the clock edge that takes the write until exactly 16·H cycles later.
- R3: The half period H is 2^d system cycles, where d is control bits [1:0]. `sclk` is 0 in the first half period after a start and is 1 in every odd-numbered half period of the transfer.
- R4: During a send, `sdo` carries byte bit 7−i in half periods 2i and 2i+1. The data is sent MSB first and changes only when `sclk` falls.
- R5: `sdo_oe` is 1 for exactly the cycles in which a send transfer is busy. It is 0 during receive transfers and while idle.
- R6: A write to address 2 with data bit 0 set starts a receive transfer while idle. `sdi` is shifted in MSB first at each rising `sclk` edge. The byte is read back at address 1. A write to address 2 with bit 0 clear starts nothing.
- R7: Control bit 2 enables a slave and control bit 3 picks which one: 0 selects `sel_n[0]`, 1 selects `sel_n[1]`. The chosen enable is driven low, at most one enable is low at a time, and the enables do not change during a transfer.
- R8: While busy, writes to every address are ignored. This covers the control register and any new start.
- R9: Status at address 2 reads bit 0 = busy and bit 1 = done. Done is set when a transfer finishes and cleared by the next start.
- R10: Reading address 0 returns control bits [3:0] with the upper bits 0. Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| sclk | output | 1 | Serial clock, idles low |
| sel_n | output | 2 | Active-low slave enables |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for the shared data line |
| sdi | input | 1 | Serial data in value |

## Verification
The assertions assume that software does not expect a write to take effect while a transfer is busy. They also assume the divider field is stable for the whole of a transfer, which R8 guarantees because control writes are dropped while busy. The bench follows the same polling discipline: it waits on its own model's busy flag before it starts the next transfer. It also deliberately issues control and transmit writes in the middle of a transfer to show that they are discarded. The incoming data line is driven with fresh random bits on every falling system clock edge. Each bit therefore holds steady over the rising edge where the block samples it.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } ssm_state_e;

    localparam int unsigned SSM_ADDR_W = 2;
    localparam logic [SSM_ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [SSM_ADDR_W-1:0] ADDR_DATA = 2'd1;
    localparam logic [SSM_ADDR_W-1:0] ADDR_CMD  = 2'd2;
    localparam logic [SSM_ADDR_W-1:0] ADDR_NONE = 2'd3;
endpackage

// File: rtl/ssm_regs.sv
module ssm_regs
    import ssm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SSM_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  busy,
    output logic [DIV_W+1:0]      ctrl,
    output logic                  start_wr,
    output logic                  start_rd
);
    localparam int CTRL_W = DIV_W + 2;

    logic accept;
    assign accept   = wr_en && !busy;
    assign start_wr = accept && (wr_addr == ADDR_DATA);
    assign start_rd = accept && (wr_addr == ADDR_CMD) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (accept && (wr_addr == ADDR_CTRL)) begin
            ctrl <= wr_data[CTRL_W-1:0];
        end
    end

    AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(ctrl)); // R8
endmodule

// File: rtl/ssm_tick.sv
module ssm_tick #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        span  = (CNT_W+1)'(1) << div;
        limit = CNT_W'(span - 1'b1);
    end

    assign tick = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt <= limit); // R3
endmodule

// File: rtl/ssm_fsm.sv
module ssm_fsm
    import ssm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_rd,
    input  logic tick,
    output logic sclk,
    output logic busy,
    output logic is_wr,
    output logic done,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int BIT_W = $clog2(DATA_W);

    ssm_state_e       state, nxt;
    logic [BIT_W-1:0] bit_idx;
    logic             last_bit;
    logic             finish;
    logic             start;

    assign start    = start_wr || start_rd;
    assign last_bit = (bit_idx == BIT_W'(DATA_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_LOW;
            ST_LOW:  if (tick)  nxt = ST_HIGH;
            ST_HIGH: if (tick)  nxt = last_bit ? ST_IDLE : ST_LOW;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        sclk     = (state == ST_HIGH);
        busy     = (state != ST_IDLE);
        rise_evt = (state == ST_LOW)  && tick;
        fall_evt = (state == ST_HIGH) && tick && !last_bit;
        finish   = (state == ST_HIGH) && tick && last_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            is_wr   <= 1'b0;
            done    <= 1'b0;
        end else if (start && !busy) begin
            bit_idx <= '0;
            is_wr   <= start_wr;
            done    <= 1'b0;
        end else begin
            if (fall_evt) bit_idx <= bit_idx + 1'b1;
            if (finish)   done    <= 1'b1;
        end
    end

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(is_wr)); // R5
endmodule

// File: rtl/ssm_shift.sv
module ssm_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              fall_evt,
    input  logic              rise_evt,
    input  logic              capture,
    input  logic              busy,
    input  logic              sdi,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_byte
);
    logic [DATA_W-1:0] tx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (load) begin
            tx_sh <= load_data;
        end else if (fall_evt) begin
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte <= '0;
        end else if (rise_evt && capture) begin
            rx_byte <= {rx_byte[DATA_W-2:0], sdi};
        end
    end

    assign sdo = tx_sh[DATA_W-1];

    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$past(fall_evt) |-> $stable(sdo)); // R4
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
    import ssm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SSM_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [SSM_ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  sclk,
    output logic [1:0]            sel_n,
    output logic                  sdo,
    output logic                  sdo_oe,
    input  logic                  sdi
);
    localparam int NUM_SLAVES = 2;
    localparam int EN_BIT     = DIV_W;
    localparam int PICK_BIT   = DIV_W + 1;

    logic [DIV_W+1:0]  ctrl;
    logic              start_wr, start_rd;
    logic              busy, is_wr, done;
    logic              tick, rise_evt, fall_evt;
    logic [DATA_W-1:0] rx_byte;

    ssm_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .ctrl(ctrl),
        .start_wr(start_wr), .start_rd(start_rd)
    );

    ssm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clear(start_wr || start_rd), .run(busy),
        .div(ctrl[DIV_W-1:0]), .tick(tick)
    );

    ssm_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
        .tick(tick), .sclk(sclk), .busy(busy), .is_wr(is_wr), .done(done),
        .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    ssm_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(start_wr || start_rd), .load_data(wr_data),
        .fall_evt(fall_evt), .rise_evt(rise_evt), .capture(!is_wr), .busy(busy),
        .sdi(sdi), .sdo(sdo), .rx_byte(rx_byte)
    );

    assign sdo_oe = busy && is_wr;

    for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_sel
        assign sel_n[s] = ~(ctrl[EN_BIT] && (int'(ctrl[PICK_BIT]) == s));
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL: rd_data = DATA_W'(ctrl);
            ADDR_DATA: rd_data = rx_byte;
            ADDR_CMD:  rd_data = DATA_W'({done, busy});
            ADDR_NONE: rd_data = '0;
            default:   rd_data = '0;
        endcase
    end

    AST_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sdo_oe) && busy |-> sdo_oe); // R5
    AST_SEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(sel_n)); // R7
    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n)); // R7
endmodule

// File: tb/sync_serial_master_bench.sv
module sync_serial_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic       sdi = 1'b0;
    logic [7:0] rd_data;
    logic       sclk, sdo, sdo_oe;
    logic [1:0] sel_n;

    always #10 clk = ~clk;

    sync_serial_master u_sync_serial_master (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sclk(sclk), .sel_n(sel_n), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference model
    logic [3:0] m_ctrl;
    bit         m_busy, m_done, m_wr;
    int         m_t, m_h;
    logic [7:0] m_tx, m_rx;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 4'd0; m_busy = 0; m_done = 0; m_wr = 0;
            m_t = 0; m_h = 1; m_tx = 8'd0; m_rx = 8'd0;
        end else if (m_busy) begin
            m_t++;
            if (!m_wr && (m_t % m_h == 0) && ((m_t / m_h) % 2 == 1))
                m_rx = {m_rx[6:0], sdi};
            if (m_t == 16 * m_h) begin
                m_busy = 0;
                m_done = 1;
            end
        end else if (wr_en) begin
            case (wr_addr)
                2'd0: m_ctrl = wr_data[3:0];
                2'd1: begin
                    m_busy = 1; m_done = 0; m_wr = 1; m_t = 0;
                    m_h = 1 << m_ctrl[1:0]; m_tx = wr_data;
                end
                2'd2: if (wr_data[0]) begin
                    m_busy = 1; m_done = 0; m_wr = 0; m_t = 0;
                    m_h = 1 << m_ctrl[1:0];
                end
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            logic       e_sclk, e_oe;
            logic [1:0] e_sel;
            e_sclk = m_busy && ((m_t / m_h) % 2 == 1);
            e_oe   = m_busy && m_wr;
            e_sel[0] = !(m_ctrl[2] && !m_ctrl[3]);
            e_sel[1] = !(m_ctrl[2] && m_ctrl[3]);
            check("R3", "sclk", 32'(sclk), 32'(e_sclk));
            check("R5", "sdo_oe", 32'(sdo_oe), 32'(e_oe));
            check("R7", "sel_n", 32'(sel_n), 32'(e_sel));
            if (e_oe) check("R4", "sdo", 32'(sdo), 32'(m_tx[7 - m_t / (2 * m_h)]));
            case (rd_addr)
                2'd0: check("R10 R8", "ctrl readback", 32'(rd_data), 32'(m_ctrl));
                2'd1: check("R6", "rx byte", 32'(rd_data), 32'(m_rx));
                2'd2: check("R2 R9", "status", 32'(rd_data), 32'({m_done, m_busy}));
                default: check("R10", "unused address", 32'(rd_data), 32'd0);
            endcase
        end
    end

    task automatic step();
        @(negedge clk);
        #2;
        rd_addr = rd_addr + 2'd1;
        sdi = 1'($urandom);
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        step();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (m_busy && guard < 1000) begin
            step();
            guard++;
        end
        repeat (3) step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #1;
            check("R1", "reset register readback", 32'(rd_data), 32'd0);
        end
        check("R1", "reset sclk", 32'(sclk), 32'd0);
        check("R1", "reset sel_n", 32'(sel_n), 32'd3);
        check("R1", "reset sdo_oe", 32'(sdo_oe), 32'd0);
        @(negedge clk);
        #2 rst_n = 1'b1;

        for (int d = 0; d < 4; d++) begin
            for (int p = 0; p < 2; p++) begin
                write_reg(2'd0, 8'({p[0], 1'b1, 2'(d)}));
                // send transfer, with stray writes while busy (R8)
                write_reg(2'd1, 8'(8'hA5 ^ (d * 37 + p * 91)));
                step();
                write_reg(2'd0, 8'h00);
                write_reg(2'd1, 8'hFF);
                write_reg(2'd2, 8'h01);
                wait_idle();
                // receive transfer, back to back on the same slave
                write_reg(2'd2, 8'h01);
                wait_idle();
            end
        end
        // command with bit 0 clear starts nothing (R6)
        write_reg(2'd2, 8'hFE);
        repeat (6) step();
        // release the slave enables
        write_reg(2'd0, 8'h00);
        repeat (6) step();

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule